// File: doc/BRIEF.md
# Reclocker Lock Qualifier with Output Muting

This block decides whether a serial data reclocker is really locked, and it gates the reclocked data on that decision. It runs in one clock domain. Each cycle it may receive one recovered bit, marked by a strobe, together with the phase-lock flag from the analog loop. From these it builds three verdicts. The first says the line carries data, meaning it toggles often enough. The second is the phase-lock flag itself. The third says the loop has not settled on a harmonic: a loop running at twice the bit rate samples every bit twice, so it can never produce an isolated single bit.

The lock output rises only when all three verdicts hold together. It falls only after the combined verdict has stayed false for a programmable grace interval. Because of this, a short input switchover passes without a glitch on the lock output or on the data output. While the block is unlocked, the serial output keeps the last level it passed and does not follow the input. The downstream logic therefore never sees amplified noise. All windows are parameters expressed in clock cycles. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `rclk_lockmute`

## Requirements
- R1: While reset is asserted, and after it is released, `lock_out` is 0 and `sdo` is 0 until the lock conditions are first met.
- R2: A transition is a strobed bit that differs from the previous strobed bit. If ACT_WIN cycles pass without a transition, the data-present verdict fails.
- R3: The no-harmonic verdict holds only while the last three strobed bits read 101 or 010 at least once per HARM_WIN cycles. A double-clocked stream (110011 / 001100) keeps `lock_out` low.
- R4: `lock_out` rises one cycle after data-present, `pll_ok` and no-harmonic are all true in the same cycle. It never rises while any one of them is false.
- R5: Once locked, `lock_out` stays high through fewer than GRACE consecutive cycles of a false combined verdict. It falls after GRACE consecutive false cycles.
- R6: While `lock_out` is 0, `sdo` does not change, whatever the data input does.
- R7: While `lock_out` is 1, each strobed bit appears on `sdo` one cycle later. Without a strobe, `sdo` holds its value.
- R8: A strobe that falls in the same cycle as the edge that raises `lock_out` is not passed to `sdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| bit_in | input | 1 | Reclocked serial data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` as a new bit |
| pll_ok | input | 1 | Phase-lock indication from the analog loop |
| lock_out | output | 1 | Qualified lock indication |
| sdo | output | 1 | Serial data output, frozen while unlocked |

## Verification
The lock register and the output gate act on the same clock edge, so a data strobe can fall in the very cycle in which `lock_out` rises. The bench provokes this by applying a strobe on every cycle of a fresh acquisition after reset. The bit that lines up with the rising edge is a 1. The bench judges the result by requiring `sdo` to still read 0 at that edge and to take the following strobed bit. In the same way, the grace counter and the window monitors can both expire close together. Phase-lock dropouts just below and well above GRACE are checked against the lock output.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lk_state_t;

  // counter width needed to hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rlm_bitwatch.sv
module rlm_bitwatch (
  input  logic clk,
  input  logic rst_s,
  input  logic bit_in,
  input  logic bit_vld,
  output logic edge_ev,
  output logic iso_ev
);
  logic [2:0] sh_q, sh_d;
  logic [1:0] fill_q, fill_d;
  logic       new_q, new_d;

  always_comb begin
    sh_d   = sh_q;
    fill_d = fill_q;
    new_d  = bit_vld;
    if (bit_vld) begin
      sh_d = {sh_q[1:0], bit_in};
      if (fill_q != 2'd3) fill_d = fill_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sh_q   <= '0;
      fill_q <= '0;
      new_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      fill_q <= fill_d;
      new_q  <= new_d;
    end
  end

  // transition relative to the previously strobed bit
  assign edge_ev = bit_vld & (bit_in ^ sh_q[0]);
  // isolated bit seen in a freshly shifted, fully filled window
  assign iso_ev  = new_q & (fill_q == 2'd3) & ((sh_q == 3'b101) | (sh_q == 3'b010));
endmodule

// File: rtl/rlm_winmon.sv
module rlm_winmon #(
  parameter int unsigned WIN = 200
) (
  input  logic clk,
  input  logic rst_s,
  input  logic ev,
  output logic ok
);
  localparam int unsigned CW = rlm_pkg::cnt_w(WIN);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;

  always_comb begin
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (ev) begin
      cnt_d = '0;
      ok_d  = 1'b1;
    end else if (cnt_q == LAST) begin
      ok_d  = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign ok = ok_q;
endmodule

// File: rtl/rlm_lockctl.sv
module rlm_lockctl #(
  parameter int unsigned GRACE = 100
) (
  input  logic clk,
  input  logic rst_s,
  input  logic cond,
  output logic lock
);
  import rlm_pkg::*;
  localparam int unsigned GW = cnt_w(GRACE);
  localparam logic [GW-1:0] GLAST = GW'(GRACE - 1);

  lk_state_t     st_q, st_d;
  logic [GW-1:0] g_q, g_d;

  always_comb begin
    st_d = st_q;
    g_d  = g_q;
    unique case (st_q)
      LK_OPEN: begin
        g_d = '0;
        if (cond) st_d = LK_HELD;
      end
      LK_HELD: begin
        if (cond) begin
          g_d = '0;
        end else if (g_q == GLAST) begin
          g_d  = '0;
          st_d = LK_OPEN;
        end else begin
          g_d = g_q + 1'b1;
        end
      end
      default: st_d = LK_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= LK_OPEN;
      g_q  <= '0;
    end else begin
      st_q <= st_d;
      g_q  <= g_d;
    end
  end

  assign lock = (st_q == LK_HELD);
endmodule

// File: rtl/rclk_lockmute.sv
module rclk_lockmute #(
  parameter int unsigned ACT_WIN  = 200,
  parameter int unsigned HARM_WIN = 30000,
  parameter int unsigned GRACE    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic pll_ok,
  output logic lock_out,
  output logic sdo
);
  logic [1:0] rsync_q;
  logic       rst_s;
  logic       edge_ev, iso_ev;
  logic       act_ok, harm_ok;
  logic       cond_all;
  logic       lock_i;
  logic       sdo_q, sdo_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  rlm_bitwatch u_watch (
    .clk(clk), .rst_s(rst_s), .bit_in(bit_in), .bit_vld(bit_vld),
    .edge_ev(edge_ev), .iso_ev(iso_ev)
  );

  rlm_winmon #(.WIN(ACT_WIN)) u_act (
    .clk(clk), .rst_s(rst_s), .ev(edge_ev), .ok(act_ok)
  );

  rlm_winmon #(.WIN(HARM_WIN)) u_harm (
    .clk(clk), .rst_s(rst_s), .ev(iso_ev), .ok(harm_ok)
  );

  assign cond_all = act_ok & harm_ok & pll_ok;

  rlm_lockctl #(.GRACE(GRACE)) u_lock (
    .clk(clk), .rst_s(rst_s), .cond(cond_all), .lock(lock_i)
  );

  // output gate: pass strobed bits only while locked, else hold
  always_comb begin
    sdo_d = sdo_q;
    if (lock_i && bit_vld) sdo_d = bit_in;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) sdo_q <= 1'b0;
    else        sdo_q <= sdo_d;
  end

  assign lock_out = lock_i;
  assign sdo      = sdo_q;
endmodule

// File: rtl/rclk_lockmute_chk.sv
module rclk_lockmute_chk #(
  parameter int unsigned GRACE = 100
) (
  input logic clk,
  input logic rst_s,
  input logic bit_in,
  input logic bit_vld,
  input logic pll_ok,
  input logic cond_all,
  input logic lock_out,
  input logic sdo
);
  localparam int unsigned MW = rlm_pkg::cnt_w(GRACE);
  localparam logic [MW-1:0] MSAT = MW'(GRACE);

  logic [MW-1:0] miss_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)               miss_q <= '0;
    else if (cond_all)        miss_q <= '0;
    else if (miss_q != MSAT)  miss_q <= miss_q + 1'b1;
  end

  AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !lock_out |=> $stable(sdo)); // R6

  AST_PASS_BIT: assert property (@(posedge clk) disable iff (!rst_s)
    (lock_out && bit_vld) |=> (sdo == $past(bit_in))); // R7

  AST_RISE_ALL: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(lock_out) |-> ($past(cond_all) && $past(pll_ok))); // R4

  AST_GRACE_FALL: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(lock_out) |-> (miss_q >= MSAT)); // R5
endmodule

bind rclk_lockmute rclk_lockmute_chk #(.GRACE(GRACE)) u_chk (
  .clk(clk), .rst_s(rst_s), .bit_in(bit_in), .bit_vld(bit_vld),
  .pll_ok(pll_ok), .cond_all(cond_all), .lock_out(lock_out), .sdo(sdo)
);

// File: tb/sim_rclk_lockmute.sv
module sim_rclk_lockmute;
  localparam int unsigned ACT_WIN  = 16;
  localparam int unsigned HARM_WIN = 64;
  localparam int unsigned GRACE    = 6;
  localparam int          WD_LIMIT = 20000;

  logic clk;
  logic rst_n;
  logic bit_in;
  logic bit_vld;
  logic pll_ok;
  logic lock_out;
  logic sdo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ph     = 0;

  rclk_lockmute #(.ACT_WIN(ACT_WIN), .HARM_WIN(HARM_WIN), .GRACE(GRACE)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .pll_ok(pll_ok), .lock_out(lock_out), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // vector: [15] pll, [14:13] mode (0 alt, 1 double-clocked, 2 idle low),
  //         [12:5] length, [4] expected lock, [3:0] requirement number
  localparam logic [15:0] TBL [13] = '{
    {1'b1, 2'd0, 8'd40,  1'b1, 4'd4},  // R4 all three conditions met
    {1'b1, 2'd1, 8'd40,  1'b1, 4'd3},  // R3 harmonic window not yet expired
    {1'b1, 2'd1, 8'd60,  1'b0, 4'd3},  // R3 double-clocked stream drops lock
    {1'b1, 2'd1, 8'd100, 1'b0, 4'd3},  // R3 stays low on harmonic stream
    {1'b1, 2'd0, 8'd20,  1'b1, 4'd4},  // R4 relock on isolated bits
    {1'b0, 2'd0, 8'd4,   1'b1, 4'd5},  // R5 short phase dropout held
    {1'b1, 2'd0, 8'd10,  1'b1, 4'd5},  // R5 recovered
    {1'b0, 2'd0, 8'd10,  1'b0, 4'd5},  // R5 long dropout drops lock
    {1'b1, 2'd0, 8'd10,  1'b1, 4'd4},  // R4 relock
    {1'b1, 2'd2, 8'd10,  1'b1, 4'd2},  // R2 short idle tolerated
    {1'b1, 2'd0, 8'd10,  1'b1, 4'd2},  // R2 data back
    {1'b1, 2'd2, 8'd40,  1'b0, 4'd2},  // R2 data absent drops lock
    {1'b1, 2'd0, 8'd10,  1'b1, 4'd4}   // R4 relock after absence
  };

  function automatic string rtag(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic gen_bit(input logic [1:0] mode, input int p);
    case (mode)
      2'd0:    return ~p[0];
      2'd1:    return ~p[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic b, input logic v);
    @(negedge clk);
    bit_in  = b;
    bit_vld = v;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    bit_in  = 1'b0;
    bit_vld = 1'b0;
    pll_ok  = 1'b0;
    #7;
    chk(lock_out, 1'b0, "R1", "lock in reset");
    chk(sdo, 1'b0, "R1", "sdo in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(lock_out, 1'b0, "R1", "lock after release");
    ph = 0;
  endtask

  initial begin
    logic held;
    logic got_rise;
    do_reset();

    for (int e = 0; e < 13; e++) begin
      pll_ok = TBL[e][15];
      for (int k = 0; k < int'(TBL[e][12:5]); k++) begin
        step(gen_bit(TBL[e][14:13], ph), 1'b1);
        ph = ph + 1;
      end
      chk(lock_out, TBL[e][4], rtag(int'(TBL[e][3:0])), $sformatf("lock at end of vector %0d", e));
    end

    // R6: force unlock by phase loss, then toggle data; sdo must hold
    pll_ok = 1'b0;
    for (int k = 0; k < 10; k++) begin step(~ph[0], 1'b1); ph = ph + 1; end
    chk(lock_out, 1'b0, "R6", "unlocked before mute test");
    held = sdo;
    for (int k = 0; k < 8; k++) begin
      step(~ph[0], 1'b1);
      ph = ph + 1;
      chk(sdo, held, "R6", "sdo frozen while unlocked");
    end

    // R7: relock and verify pass-through
    pll_ok = 1'b1;
    for (int k = 0; k < 10; k++) begin step(~ph[0], 1'b1); ph = ph + 1; end
    chk(lock_out, 1'b1, "R7", "relocked for pass test");
    step(1'b1, 1'b1); chk(sdo, 1'b1, "R7", "strobed 1 passed");
    step(1'b0, 1'b1); chk(sdo, 1'b0, "R7", "strobed 0 passed");
    step(1'b1, 1'b1); chk(sdo, 1'b1, "R7", "strobed 1 passed");
    step(1'b0, 1'b0); chk(sdo, 1'b1, "R7", "no strobe holds");
    step(1'b0, 1'b0); chk(sdo, 1'b1, "R7", "no strobe holds");
    chk(lock_out, 1'b1, "R7", "lock kept across short strobe gap");

    // R8: strobe coincident with the rising lock edge is not passed
    do_reset();
    pll_ok   = 1'b1;
    got_rise = 1'b0;
    for (int k = 0; k < 20 && !got_rise; k++) begin
      step(~ph[0], 1'b1);
      ph = ph + 1;
      if (lock_out) begin
        got_rise = 1'b1;
        chk(sdo, 1'b0, "R8", "bit at lock edge not passed");
      end
    end
    chk(got_rise, 1'b1, "R8", "lock rose during acquisition");
    step(1'b1, 1'b1);
    chk(sdo, 1'b1, "R8", "next strobed bit passed");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule